// File: doc/BRIEF.md
# 128-bit Lane Permuter

The lane permuter rearranges the 32-bit words, 16-bit halfwords and bytes of two 128-bit source operands into one 128-bit result. The operations are interleaving, packing, broadcasting, doubleword copying and a three-word rotation. Word 0 is bits 31:0. The first operand is `rsData` and the second is `rtData`. A 4-bit function code picks the shuffle. The permutation itself is combinational. Its result is captured in an output register, which drives a write-back port made of the result, a one-cycle valid pulse and the destination register index.

Each request is a one-cycle `validIn` strobe. The strobe carries the function code, the two source register indices and the destination register index. A source index of zero makes that operand read as all zeros, whatever value is on its data port. A destination index of zero turns the request into a no-op. The output register updates only on an accepted request and holds its value at all other times.

Top module: `lane_permuter`

## Requirements
- R1: After reset, `resOut` is zero, `resValid` is low and `resDest` is zero.
- R2: Code 1 (lower byte interleave): result byte 2i is byte i of rt and result byte 2i+1 is byte i of rs, for i = 0..7.
- R3: Code 2 (lower halfword interleave): result halfword 2i is halfword i of rt and result halfword 2i+1 is halfword i of rs, for i = 0..3.
- R4: Code 3 gives, from word 0 upward, rt.w0, rs.w0, rt.w1, rs.w1. Code 4 gives rt.w2, rs.w2, rt.w3, rs.w3.
- R5: Code 5 (even-word pack) gives, from word 0 upward, rt.w0, rt.w2, rs.w0, rs.w2.
- R6: Code 6 (halfword broadcast) fills all four halfwords of each 64-bit half of the result with halfword 0 of the same half of rt.
- R7: Code 7 puts rt bits 63:0 in result bits 63:0 and rs bits 63:0 in bits 127:64. Code 8 puts rs bits 127:64 in bits 63:0 and rt bits 127:64 in bits 127:64.
- R8: Code 9 (three-word rotate) gives, from word 0 upward, rt.w1, rt.w2, rt.w0, rt.w3.
- R9: A request whose `rdIdx` is 0 leaves `resOut` unchanged and raises no `resValid`.
- R10: An operand whose index (`rsIdx` or `rtIdx`) is 0 reads as all zeros, regardless of its data port.
- R11: Codes 0 and 10 to 15 pass rt through unchanged.
- R12: An accepted request updates `resOut` and `resDest` at the next rising clock edge and pulses `resValid` high for exactly that one cycle. Without a request, `resOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Request strobe |
| funcSel | input | 4 | Shuffle function code |
| rsIdx | input | 5 | First source register index, 0 reads zero |
| rtIdx | input | 5 | Second source register index, 0 reads zero |
| rdIdx | input | 5 | Destination index, 0 suppresses the write |
| rsData | input | 128 | First source operand |
| rtData | input | 128 | Second source operand |
| resOut | output | 128 | Registered result |
| resValid | output | 1 | One-cycle pulse on each result update |
| resDest | output | 5 | Destination index of the current result |

## Verification
The embedded properties check the cycle-level contract on every clock:
- the output holds when no request is accepted;
- `resValid` pulses exactly one cycle after each accepted request;
- a destination of zero never loads the register;
- two zeroed sources always produce an all-zero result;
- the top word of the rotate and the low half of copy-lower carry the right source bits.

The exact lane ordering of every interleave, pack, broadcast and copy is not covered by those properties. The same holds for the pass-through of unused codes. These behaviours are shown only by the bench scenarios, which use operands with distinct bytes so that any misrouted lane shows up in the compared result.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [3:0] {
    FN_PASS     = 4'd0,
    FN_ILV_LO_B = 4'd1,
    FN_ILV_LO_H = 4'd2,
    FN_ILV_LO_W = 4'd3,
    FN_ILV_HI_W = 4'd4,
    FN_PACK_EVW = 4'd5,
    FN_BCAST_H  = 4'd6,
    FN_COPY_LOD = 4'd7,
    FN_COPY_HID = 4'd8,
    FN_ROT3_W   = 4'd9
  } permFn_e;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic    loadEn;
    logic    zeroRs;
    logic    zeroRt;
    permFn_e fn;
  } permStrb_t;

endpackage

// File: rtl/perm_ctrl.sv
module perm_ctrl #(
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                validIn,
  input  logic [3:0]          funcSel,
  input  logic [IDX_W-1:0]    rsIdx,
  input  logic [IDX_W-1:0]    rtIdx,
  input  logic [IDX_W-1:0]    rdIdx,
  output perm_pkg::permStrb_t strb
);
  import perm_pkg::*;

  permFn_e fnDec;

  always_comb begin
    case (funcSel)
      4'd1:    fnDec = FN_ILV_LO_B;
      4'd2:    fnDec = FN_ILV_LO_H;
      4'd3:    fnDec = FN_ILV_LO_W;
      4'd4:    fnDec = FN_ILV_HI_W;
      4'd5:    fnDec = FN_PACK_EVW;
      4'd6:    fnDec = FN_BCAST_H;
      4'd7:    fnDec = FN_COPY_LOD;
      4'd8:    fnDec = FN_COPY_HID;
      4'd9:    fnDec = FN_ROT3_W;
      default: fnDec = FN_PASS;
    endcase
  end

  always_comb begin
    strb.loadEn = validIn && (rdIdx != '0);
    strb.zeroRs = (rsIdx == '0);
    strb.zeroRt = (rtIdx == '0);
    strb.fn     = fnDec;
  end

  AST_DEST_ZERO_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && rdIdx == '0) |-> !strb.loadEn); // R9

  AST_UNUSED_IS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel > 4'd9) |-> (strb.fn == FN_PASS)); // R11

endmodule

// File: rtl/perm_datapath.sv
module perm_datapath #(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  perm_pkg::permStrb_t strb,
  input  logic [IDX_W-1:0]    destIdx,
  input  logic [DATA_W-1:0]   rsData,
  input  logic [DATA_W-1:0]   rtData,
  output logic [DATA_W-1:0]   resOut,
  output logic                resValid,
  output logic [IDX_W-1:0]    resDest
);
  import perm_pkg::*;

  localparam int WL     = 32;
  localparam int HL     = 16;
  localparam int HALF   = DATA_W / 2;
  localparam int NWORD  = DATA_W / WL;
  localparam int NDWORD = DATA_W / 64;

  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] ilvHiW;
  logic [DATA_W-1:0] packEv;
  logic [DATA_W-1:0] bcastH;
  logic [DATA_W-1:0] rot3W;
  logic [DATA_W-1:0] permRes;

  assign opA = strb.zeroRs ? '0 : rsData;
  assign opB = strb.zeroRt ? '0 : rtData;

  // Lower-half interleave at byte, halfword and word lane widths
  for (genvar g = 0; g < 3; g++) begin : gIlvLo
    localparam int LW = 8 << g;
    localparam int NL = HALF / LW;
    logic [DATA_W-1:0] vec;
    for (genvar i = 0; i < NL; i++) begin : gLane
      assign vec[2*i*LW +: LW]     = opB[i*LW +: LW];
      assign vec[(2*i+1)*LW +: LW] = opA[i*LW +: LW];
    end
  end

  // Upper-half word interleave
  for (genvar i = 0; i < NWORD / 2; i++) begin : gIlvHi
    assign ilvHiW[2*i*WL +: WL]     = opB[HALF + i*WL +: WL];
    assign ilvHiW[(2*i+1)*WL +: WL] = opA[HALF + i*WL +: WL];
  end

  // Even-word pack: rt even words low, rs even words high
  for (genvar k = 0; k < NWORD / 2; k++) begin : gPack
    assign packEv[k*WL +: WL]        = opB[2*k*WL +: WL];
    assign packEv[HALF + k*WL +: WL] = opA[2*k*WL +: WL];
  end

  // Halfword 0 broadcast inside each doubleword
  for (genvar d = 0; d < NDWORD; d++) begin : gBcast
    for (genvar h = 0; h < 4; h++) begin : gHw
      assign bcastH[d*64 + h*HL +: HL] = opB[d*64 +: HL];
    end
  end

  // Rotate of the three low words, top word fixed
  assign rot3W = {opB[DATA_W-1 -: WL], opB[0 +: WL], opB[2*WL +: WL], opB[WL +: WL]};

  always_comb begin
    case (strb.fn)
      FN_ILV_LO_B: permRes = gIlvLo[0].vec;
      FN_ILV_LO_H: permRes = gIlvLo[1].vec;
      FN_ILV_LO_W: permRes = gIlvLo[2].vec;
      FN_ILV_HI_W: permRes = ilvHiW;
      FN_PACK_EVW: permRes = packEv;
      FN_BCAST_H:  permRes = bcastH;
      FN_COPY_LOD: permRes = {opA[HALF-1:0], opB[HALF-1:0]};
      FN_COPY_HID: permRes = {opB[DATA_W-1:HALF], opA[DATA_W-1:HALF]};
      FN_ROT3_W:   permRes = rot3W;
      default:     permRes = opB;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOut   <= '0;
      resValid <= 1'b0;
      resDest  <= '0;
    end else begin
      resValid <= strb.loadEn;
      if (strb.loadEn) begin
        resOut  <= permRes;
        resDest <= destIdx;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> $stable(resOut)); // R12

  AST_PULSE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> resValid); // R12

  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> !resValid); // R9

  AST_ZERO_SOURCES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && strb.zeroRs && strb.zeroRt) |=> (resOut == '0)); // R10

  AST_ROT_TOP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && strb.fn == FN_ROT3_W) |=>
      (resOut[DATA_W-1 -: WL] == $past(opB[DATA_W-1 -: WL]))); // R8

  AST_COPY_LO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && strb.fn == FN_COPY_LOD) |=>
      (resOut[HALF-1:0] == $past(opB[HALF-1:0]))); // R7

endmodule

// File: rtl/lane_permuter.sv
module lane_permuter #(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [3:0]        funcSel,
  input  logic [IDX_W-1:0]  rsIdx,
  input  logic [IDX_W-1:0]  rtIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic [DATA_W-1:0] resOut,
  output logic              resValid,
  output logic [IDX_W-1:0]  resDest
);

  perm_pkg::permStrb_t strb;

  perm_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .funcSel (funcSel),
    .rsIdx   (rsIdx),
    .rtIdx   (rtIdx),
    .rdIdx   (rdIdx),
    .strb    (strb)
  );

  perm_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .destIdx  (rdIdx),
    .rsData   (rsData),
    .rtData   (rtData),
    .resOut   (resOut),
    .resValid (resValid),
    .resDest  (resDest)
  );

endmodule

// File: tb/lane_permuter_test.sv
`timescale 1ns/1ps
module lane_permuter_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [3:0]   funcSel = '0;
  logic [4:0]   rsIdx = '0;
  logic [4:0]   rtIdx = '0;
  logic [4:0]   rdIdx = '0;
  logic [127:0] rsData = '0;
  logic [127:0] rtData = '0;
  logic [127:0] resOut;
  logic         resValid;
  logic [4:0]   resDest;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [127:0] expQ[$];
  logic [4:0]   destQ[$];
  string        reqQ[$];
  logic [127:0] lastData = '0;

  always #5 clk = ~clk;

  lane_permuter uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .funcSel(funcSel),
    .rsIdx(rsIdx), .rtIdx(rtIdx), .rdIdx(rdIdx),
    .rsData(rsData), .rtData(rtData),
    .resOut(resOut), .resValid(resValid), .resDest(resDest)
  );

  // Reference model written from the requirement text
  function automatic logic [127:0] model(int fn, logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    r = b;
    case (fn)
      1: for (int i = 0; i < 8; i++) begin
           r[16*i +: 8]   = b[8*i +: 8];
           r[16*i+8 +: 8] = a[8*i +: 8];
         end
      2: for (int i = 0; i < 4; i++) begin
           r[32*i +: 16]    = b[16*i +: 16];
           r[32*i+16 +: 16] = a[16*i +: 16];
         end
      3: r = {a[63:32], b[63:32], a[31:0], b[31:0]};
      4: r = {a[127:96], b[127:96], a[95:64], b[95:64]};
      5: r = {a[95:64], a[31:0], b[95:64], b[31:0]};
      6: r = {{4{b[79:64]}}, {4{b[15:0]}}};
      7: r = {a[63:0], b[63:0]};
      8: r = {b[127:64], a[127:64]};
      9: r = {b[127:96], b[31:0], b[95:64], b[63:32]};
      default: r = b;
    endcase
    return r;
  endfunction

  function automatic string reqOf(int fn);
    case (fn)
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      6: return "R6";
      7, 8: return "R7";
      9: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one request, expected result pushed into the scoreboard
  task automatic issue(int fn, logic [4:0] si, logic [4:0] ti, logic [4:0] di,
                       logic [127:0] sd, logic [127:0] td, string tag);
    logic [127:0] a;
    logic [127:0] b;
    @(negedge clk);
    funcSel = fn[3:0];
    rsIdx = si; rtIdx = ti; rdIdx = di;
    rsData = sd; rtData = td;
    validIn = 1'b1;
    a = (si == 0) ? '0 : sd;
    b = (ti == 0) ? '0 : td;
    if (di != 0) begin
      lastData = model(fn, a, b);
      expQ.push_back(lastData);
      destQ.push_back(di);
      reqQ.push_back(tag == "" ? reqOf(fn) : tag);
    end
    @(negedge clk);
    validIn = 1'b0;
  endtask

  // Monitor: compare each produced result with the scoreboard head (R12)
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 actual=unexpected result %h expected=no result", resOut);
      end else begin
        check(reqQ.pop_front(), resOut, expQ.pop_front());
        check("R12", {123'd0, resDest}, {123'd0, destQ.pop_front()});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [127:0] PA = 128'h8f8e8d8c_8b8a8988_87868584_83828180;
  localparam logic [127:0] PB = 128'h1f1e1d1c_1b1a1918_17161514_13121110;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", resOut, '0);
    check("R1", {126'd0, resValid, 1'b0}, '0);
    check("R1", {123'd0, resDest}, '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int fn = 1; fn <= 9; fn++) issue(fn, 5'd3, 5'd4, 5'd7, PA, PB, "");
    issue(6, 5'd1, 5'd2, 5'd9, PB, PA, "R6");
    issue(9, 5'd1, 5'd2, 5'd9, PB, PA, "R8");
    issue(1, 5'd1, 5'd2, 5'd30, ~PB, PA ^ PB, "R2");
    // R11 unused and pass codes
    issue(0, 5'd3, 5'd4, 5'd5, PA, PB, "R11");
    issue(12, 5'd3, 5'd4, 5'd6, PA, PB, "R11");
    issue(15, 5'd3, 5'd4, 5'd6, PB, PA, "R11");
    // R10 source index zero reads zero
    issue(7, 5'd0, 5'd4, 5'd8, PA, PB, "R10");
    issue(8, 5'd3, 5'd0, 5'd8, PA, PB, "R10");
    issue(3, 5'd0, 5'd0, 5'd8, PA, PB, "R10");
    // R9 destination zero: no update, no pulse
    issue(5, 5'd3, 5'd4, 5'd7, PA, PB, "R5");
    issue(1, 5'd3, 5'd4, 5'd0, ~PA, ~PB, "R9");
    check("R9", resOut, lastData);
    check("R9", {127'd0, resValid}, '0);
    // R12 hold with no request
    repeat (4) @(negedge clk);
    check("R12", resOut, lastData);
    check("R12", {127'd0, resValid}, '0);

    repeat (3) @(negedge clk);
    check("R12", {96'd0, 32'(expQ.size())}, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule